// File: doc/BRIEF.md
# Closed-Loop Oscillator Frequency Lock Controller

This block steers a supply-voltage index so that a free-running, voltage-dependent oscillator settles at a requested rate. It runs on the reference clock. The oscillator is represented by a stream of edge counts. Over each sample window the block totals the oscillator edges and compares the total with the count that a perfect lock would give. That expected count is the request multiplier times half the reference rate, taken over the window. The signed difference is divided by a power of two and added to a fractional integrator. The whole-number part of the integrator, held inside the programmed limits, is the voltage index that goes to the regulator side.

Software sets a mode and writes frequency requests. Open-loop mode keeps the oscillator counted but leaves the index alone. Closed-loop mode runs the integrator. A request that arrives outside closed loop is parked and takes effect on the next entry to closed loop. A request can also preload the integrator at an offset from the safe index, one step above the lower limit, so that a rate change starts close to the right voltage. When the integrator has to be clipped at either limit, a sticky status flag is set. Writing a one to that flag's clear input clears it.

The edge stream uses valid/ready. `edge_ready` is high in every mode except disabled. A beat transfers on a cycle where both `edge_valid` and `edge_ready` are high. The block never stalls the stream while it is enabled. A source that holds data while `edge_ready` is low loses nothing, and those beats are not counted.

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset the block is disabled (`mode_state` = 0), `out_scale` is 0, both flags are clear, and `out_index` equals `lim_min`.
- R2: The `mode_sel` codes are 0 for disabled, 1 for open loop and 2 for closed loop, and 3 acts as disabled. `mode_state` reports the same codes one cycle later. From disabled, any request to run first passes through open loop for one cycle. Closed loop is entered only from open loop. Leaving closed loop takes effect at once.
- R3: Entry to closed loop is refused while the multiplier that would become active is zero, and the block stays in open loop.
- R4: A request write with `req_valid` clear is ignored. Outside closed loop, a valid write is parked and becomes active, with its scale, on entry to closed loop. In closed loop, a valid write with a non-zero multiplier becomes active on the next cycle, and one with a zero multiplier is discarded.
- R5: A sample window lasts `div_cfg` × 32 reference cycles and restarts on entry to closed loop. A `div_cfg` of 0 produces no windows and so no index updates.
- R6: At each window end in closed loop, the integrator (in units of 1/2^FRAC_W index) grows by (multiplier × `div_cfg` × 16 − counted edges) arithmetically shifted right by GAIN_SH. `out_index` is the integrator shifted right by FRAC_W.
- R7: A valid request with `req_force_en` set makes the first window end after it takes effect load the integrator with (`lim_min` + 1) × 2^FRAC_W + `req_force`, a signed value. This load replaces the error update for that window.
- R8: In disabled and open-loop modes the integrator, and so `out_index` under fixed limits, does not change.
- R9: Whenever `lim_min` ≤ `lim_max`, `out_index` lies within them, including in the same cycle that a limit is changed.
- R10: Every integrator update or load is clipped to [`lim_min` × 2^FRAC_W, `lim_max` × 2^FRAC_W + 2^FRAC_W − 1]. Clipping at the low end sets `flag_min`, and clipping at the high end sets `flag_max`.
- R11: Each flag stays set until a one is written on its clear input. A new clip in the same cycle wins over the clear.
- R12: `edge_ready` is low only when disabled. The edge total saturates rather than wrapping. Edges counted before entry to closed loop are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested mode: 0 disabled, 1 open, 2 closed |
| div_cfg | input | DIV_W | Sample window length in units of 32 cycles |
| lim_min | input | IDX_W | Lowest permitted voltage index |
| lim_max | input | IDX_W | Highest permitted voltage index |
| req_wr | input | 1 | Frequency request write strobe |
| req_mult | input | MULT_W | Target rate in units of half the reference rate |
| req_scale | input | SCALE_W | Output scale setting carried with the request |
| req_force | input | FORCE_W | Signed preload offset in integrator units |
| req_valid | input | 1 | Request valid bit; a write without it is ignored |
| req_force_en | input | 1 | Request asks for an integrator preload |
| edge_valid | input | 1 | Edge-count beat present |
| edge_ready | output | 1 | Block accepts edge-count beats |
| edge_cnt | input | EDGE_W | Oscillator edges seen since the previous beat |
| clr_min | input | 1 | Write-one clear for the low clip flag |
| clr_max | input | 1 | Write-one clear for the high clip flag |
| out_index | output | IDX_W | Clamped voltage index |
| out_scale | output | SCALE_W | Scale setting of the active request |
| mode_state | output | 2 | Effective mode, same codes as mode_sel |
| flag_min | output | 1 | Sticky low clip flag |
| flag_max | output | 1 | Sticky high clip flag |

## Verification
The hardest state to reach from the ports is a known integrator value, because its fractional bits are never visible at the outputs. Every stimulus vector therefore starts with a forced preload, which fixes the integrator exactly. Constant edge beats then give a fixed error in each window, and the index is sampled halfway between two window ends, so the number of updates applied is known for certain. The clip flags are raised by driving the integrator past each limit with a large error or a large negative preload. The zero-multiplier refusal is reached by asking for closed loop before any usable request has been written.

// File: rtl/flk_pkg.sv
package flk_pkg;
  // Effective and requested operating modes (port codes)
  typedef enum logic [1:0] {
    FLK_OFF    = 2'd0,
    FLK_OPEN   = 2'd1,
    FLK_CLOSED = 2'd2
  } flk_mode_e;

  // Sample window = div * 2^WIN_SH reference cycles
  localparam int WIN_SH  = 5;
  // Expected edges per window = mult * div * 2^(WIN_SH-1)
  localparam int HALF_SH = WIN_SH - 1;

  function automatic flk_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    return FLK_OPEN;
      2'd2:    return FLK_CLOSED;
      default: return FLK_OFF;
    endcase
  endfunction
endpackage

// File: rtl/flk_sample_timer.sv
module flk_sample_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  import flk_pkg::*;

  localparam int PER_W = DIV_W + WIN_SH;

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] last_cnt;
  logic             run;
  logic             at_end;

  assign run      = (div_cfg != '0);
  assign last_cnt = {div_cfg, {WIN_SH{1'b0}}} - PER_W'(1);
  assign at_end   = (cnt >= last_cnt);
  assign tick     = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/flk_edge_accum.sv
module flk_edge_accum #(
  parameter int EDGE_W = 4,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [EDGE_W-1:0] beat_cnt,
  input  logic              restart,
  input  logic              tick,
  output logic [CNT_W-1:0]  total,
  output logic              total_vld
);
  logic [CNT_W-1:0] acc;
  logic [CNT_W:0]   wide_sum;
  logic [CNT_W-1:0] sat_sum;

  assign wide_sum = {1'b0, acc} + (beat ? (CNT_W+1)'(beat_cnt) : '0);
  assign sat_sum  = wide_sum[CNT_W] ? {CNT_W{1'b1}} : wide_sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      total     <= '0;
      total_vld <= 1'b0;
    end else if (restart) begin
      acc       <= '0;
      total_vld <= 1'b0;
    end else if (tick) begin
      total     <= sat_sum;
      total_vld <= 1'b1;
      acc       <= '0;
    end else begin
      acc       <= sat_sum;
      total_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/flk_req_hold.sv
module flk_req_hold #(
  parameter int MULT_W  = 7,
  parameter int SCALE_W = 8,
  parameter int FORCE_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic                      wr_valid,
  input  logic [MULT_W-1:0]         wr_mult,
  input  logic [SCALE_W-1:0]        wr_scale,
  input  logic signed [FORCE_W-1:0] wr_force,
  input  logic                      wr_force_en,
  input  logic                      in_closed,
  input  logic                      enter,
  input  logic                      force_taken,
  output logic [MULT_W-1:0]         act_mult,
  output logic [SCALE_W-1:0]        act_scale,
  output logic signed [FORCE_W-1:0] act_force,
  output logic                      force_pend,
  output logic [MULT_W-1:0]         next_mult
);
  logic                      accept;
  logic                      pend_vld;
  logic [MULT_W-1:0]         pend_mult;
  logic [SCALE_W-1:0]        pend_scale;
  logic signed [FORCE_W-1:0] pend_force;
  logic                      pend_fe;

  assign accept    = wr && wr_valid;
  assign next_mult = accept ? wr_mult : (pend_vld ? pend_mult : act_mult);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mult   <= '0;
      act_scale  <= '0;
      act_force  <= '0;
      force_pend <= 1'b0;
      pend_vld   <= 1'b0;
      pend_mult  <= '0;
      pend_scale <= '0;
      pend_force <= '0;
      pend_fe    <= 1'b0;
    end else if (in_closed) begin
      if (accept && (wr_mult != '0)) begin
        act_mult   <= wr_mult;
        act_scale  <= wr_scale;
        act_force  <= wr_force;
        force_pend <= wr_force_en;
      end else if (force_taken) begin
        force_pend <= 1'b0;
      end
    end else if (enter) begin
      pend_vld <= 1'b0;
      if (accept) begin
        act_mult   <= wr_mult;
        act_scale  <= wr_scale;
        act_force  <= wr_force;
        force_pend <= wr_force_en;
      end else if (pend_vld) begin
        act_mult   <= pend_mult;
        act_scale  <= pend_scale;
        act_force  <= pend_force;
        force_pend <= pend_fe;
      end
    end else if (accept) begin
      pend_vld   <= 1'b1;
      pend_mult  <= wr_mult;
      pend_scale <= wr_scale;
      pend_force <= wr_force;
      pend_fe    <= wr_force_en;
    end
  end
endmodule

// File: rtl/flk_integrator.sv
module flk_integrator #(
  parameter int IDX_W   = 6,
  parameter int FRAC_W  = 4,
  parameter int FORCE_W = 12,
  parameter int EXP_W   = 19,
  parameter int CNT_W   = 20,
  parameter int GAIN_SH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd,
  input  logic                      load,
  input  logic signed [FORCE_W-1:0] force_val,
  input  logic [EXP_W-1:0]          expect_cnt,
  input  logic [CNT_W-1:0]          total,
  input  logic [IDX_W-1:0]          lim_min,
  input  logic [IDX_W-1:0]          lim_max,
  output logic [IDX_W-1:0]          idx_raw,
  output logic                      set_lo,
  output logic                      set_hi,
  output logic                      force_taken
);
  localparam int INT_W = IDX_W + FRAC_W;
  localparam int M1    = (CNT_W > INT_W) ? CNT_W : INT_W;
  localparam int M2    = (M1 > FORCE_W) ? M1 : FORCE_W;
  localparam int SUM_W = M2 + 3;

  logic [INT_W-1:0]        integ;
  logic signed [SUM_W-1:0] exp_s, tot_s, err_s, step_s, cur_s;
  logic signed [SUM_W-1:0] frc_s, safe_s, lo_s, hi_s, cand_s, nxt_s;
  logic                    below, above;
  logic                    unused_hi;

  always_comb begin
    exp_s  = SUM_W'(expect_cnt);
    tot_s  = SUM_W'(total);
    err_s  = exp_s - tot_s;
    step_s = err_s >>> GAIN_SH;
    cur_s  = SUM_W'(integ);
    frc_s  = SUM_W'(force_val);
    safe_s = (SUM_W'(lim_min) + SUM_W'(1)) <<< FRAC_W;
    lo_s   = SUM_W'(lim_min) <<< FRAC_W;
    hi_s   = (SUM_W'(lim_max) <<< FRAC_W) + SUM_W'((1 << FRAC_W) - 1);
    cand_s = load ? (safe_s + frc_s) : (cur_s + step_s);
    below  = (cand_s < lo_s);
    above  = !below && (cand_s > hi_s);
    if (below)      nxt_s = lo_s;
    else if (above) nxt_s = hi_s;
    else            nxt_s = cand_s;
  end

  assign unused_hi   = ^nxt_s[SUM_W-1:INT_W];
  assign set_lo      = upd && below;
  assign set_hi      = upd && above;
  assign force_taken = upd && load;
  assign idx_raw     = integ[INT_W-1:FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= '0;
    end else if (upd) begin
      integ <= nxt_s[INT_W-1:0];
    end
  end
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl #(
  parameter int MULT_W  = 7,
  parameter int SCALE_W = 8,
  parameter int FORCE_W = 12,
  parameter int DIV_W   = 8,
  parameter int IDX_W   = 6,
  parameter int FRAC_W  = 4,
  parameter int GAIN_SH = 2,
  parameter int EDGE_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode_sel,
  input  logic [DIV_W-1:0]          div_cfg,
  input  logic [IDX_W-1:0]          lim_min,
  input  logic [IDX_W-1:0]          lim_max,
  input  logic                      req_wr,
  input  logic [MULT_W-1:0]         req_mult,
  input  logic [SCALE_W-1:0]        req_scale,
  input  logic signed [FORCE_W-1:0] req_force,
  input  logic                      req_valid,
  input  logic                      req_force_en,
  input  logic                      edge_valid,
  output logic                      edge_ready,
  input  logic [EDGE_W-1:0]         edge_cnt,
  input  logic                      clr_min,
  input  logic                      clr_max,
  output logic [IDX_W-1:0]          out_index,
  output logic [SCALE_W-1:0]        out_scale,
  output logic [1:0]                mode_state,
  output logic                      flag_min,
  output logic                      flag_max
);
  import flk_pkg::*;

  localparam int PROD_W = MULT_W + DIV_W;
  localparam int EXP_W  = PROD_W + HALF_SH;
  localparam int CNT_W  = EXP_W + 1;

  flk_mode_e                 eff_mode, nxt_mode, sel_mode;
  logic                      enter, in_closed;
  logic                      tick, total_vld, upd;
  logic [CNT_W-1:0]          total;
  logic [PROD_W-1:0]         prod;
  logic [EXP_W-1:0]          expect_cnt;
  logic [MULT_W-1:0]         act_mult, next_mult;
  logic signed [FORCE_W-1:0] act_force;
  logic                      force_pend, force_taken;
  logic [IDX_W-1:0]          idx_raw;
  logic                      set_lo, set_hi;

  // Mode sequencing
  assign sel_mode  = decode_mode(mode_sel);
  assign in_closed = (eff_mode == FLK_CLOSED);
  assign enter     = (eff_mode == FLK_OPEN) && (sel_mode == FLK_CLOSED) &&
                     (next_mult != '0);

  always_comb begin
    nxt_mode = eff_mode;
    case (eff_mode)
      FLK_OFF:    if (sel_mode != FLK_OFF) nxt_mode = FLK_OPEN;
      FLK_OPEN: begin
        if (sel_mode == FLK_OFF) nxt_mode = FLK_OFF;
        else if (enter)          nxt_mode = FLK_CLOSED;
      end
      default:    if (sel_mode != FLK_CLOSED) nxt_mode = sel_mode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) eff_mode <= FLK_OFF;
    else        eff_mode <= nxt_mode;
  end

  assign mode_state = eff_mode;
  assign edge_ready = (eff_mode != FLK_OFF);

  // Window timing and edge totals
  flk_sample_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (enter),
    .div_cfg (div_cfg),
    .tick    (tick)
  );

  flk_edge_accum #(.EDGE_W(EDGE_W), .CNT_W(CNT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (edge_valid && edge_ready),
    .beat_cnt  (edge_cnt),
    .restart   (enter),
    .tick      (tick),
    .total     (total),
    .total_vld (total_vld)
  );

  // Request handling
  flk_req_hold #(.MULT_W(MULT_W), .SCALE_W(SCALE_W), .FORCE_W(FORCE_W)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (req_wr),
    .wr_valid    (req_valid),
    .wr_mult     (req_mult),
    .wr_scale    (req_scale),
    .wr_force    (req_force),
    .wr_force_en (req_force_en),
    .in_closed   (in_closed),
    .enter       (enter),
    .force_taken (force_taken),
    .act_mult    (act_mult),
    .act_scale   (out_scale),
    .act_force   (act_force),
    .force_pend  (force_pend),
    .next_mult   (next_mult)
  );

  // Expected edges per window: mult * (ref/2) * div*32/ref
  assign prod       = PROD_W'(act_mult) * PROD_W'(div_cfg);
  assign expect_cnt = {prod, {HALF_SH{1'b0}}};
  assign upd        = total_vld && in_closed;

  flk_integrator #(
    .IDX_W(IDX_W), .FRAC_W(FRAC_W), .FORCE_W(FORCE_W),
    .EXP_W(EXP_W), .CNT_W(CNT_W), .GAIN_SH(GAIN_SH)
  ) u_integ (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd         (upd),
    .load        (force_pend),
    .force_val   (act_force),
    .expect_cnt  (expect_cnt),
    .total       (total),
    .lim_min     (lim_min),
    .lim_max     (lim_max),
    .idx_raw     (idx_raw),
    .set_lo      (set_lo),
    .set_hi      (set_hi),
    .force_taken (force_taken)
  );

  // Live clamp against current limits
  always_comb begin
    if (idx_raw < lim_min)      out_index = lim_min;
    else if (idx_raw > lim_max) out_index = lim_max;
    else                        out_index = idx_raw;
  end

  // Sticky clip flags, write-one clear, set wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_min <= 1'b0;
      flag_max <= 1'b0;
    end else begin
      flag_min <= set_lo | (flag_min & ~clr_min);
      flag_max <= set_hi | (flag_max & ~clr_max);
    end
  end
endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
  parameter int IDX_W   = 6,
  parameter int SCALE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_state,
  input logic [IDX_W-1:0]   lim_min,
  input logic [IDX_W-1:0]   lim_max,
  input logic [IDX_W-1:0]   out_index,
  input logic [SCALE_W-1:0] out_scale,
  input logic               flag_min,
  input logic               clr_min,
  input logic               set_lo
);
  p_index_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_min <= lim_max) |-> (out_index >= lim_min && out_index <= lim_max));

  p_hold_outside_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state != 2'd2) ##1 ($stable(lim_min) && $stable(lim_max)) |-> $stable(out_index));

  p_scale_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state != 2'd2) ##1 (mode_state != 2'd2) |-> $stable(out_scale));

  p_entry_from_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_state == 2'd2) |-> ($past(mode_state) == 2'd1));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_min && !clr_min) |=> flag_min);

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_min && !set_lo) |=> !flag_min);
endmodule

bind freq_lock_ctrl flk_checker #(.IDX_W(IDX_W), .SCALE_W(SCALE_W)) i_flk_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_state (mode_state),
  .lim_min    (lim_min),
  .lim_max    (lim_max),
  .out_index  (out_index),
  .out_scale  (out_scale),
  .flag_min   (flag_min),
  .clr_min    (clr_min),
  .set_lo     (set_lo)
);

// File: tb/test_freq_lock_ctrl.sv
module test_freq_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [7:0]  div_cfg = 8'd1;
  logic [5:0]  lim_min = 6'd2, lim_max = 6'd40;
  logic        req_wr = 1'b0, req_valid = 1'b0, req_force_en = 1'b0;
  logic [6:0]  req_mult = '0;
  logic [7:0]  req_scale = '0;
  logic signed [11:0] req_force = '0;
  logic        edge_valid = 1'b0, edge_ready;
  logic [3:0]  edge_cnt = '0;
  logic        clr_min = 1'b0, clr_max = 1'b0;
  logic [5:0]  out_index;
  logic [7:0]  out_scale;
  logic [1:0]  mode_state;
  logic        flag_min, flag_max;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  freq_lock_ctrl i_freq_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .div_cfg(div_cfg),
    .lim_min(lim_min), .lim_max(lim_max), .req_wr(req_wr), .req_mult(req_mult),
    .req_scale(req_scale), .req_force(req_force), .req_valid(req_valid),
    .req_force_en(req_force_en), .edge_valid(edge_valid), .edge_ready(edge_ready),
    .edge_cnt(edge_cnt), .clr_min(clr_min), .clr_max(clr_max),
    .out_index(out_index), .out_scale(out_scale), .mode_state(mode_state),
    .flag_min(flag_min), .flag_max(flag_max)
  );

  // columns: min, max, mult, force, edges per cycle, windows, expected index
  localparam int NV = 8;
  localparam int VEC [0:NV-1][0:6] = '{
    '{2, 40, 4,    0, 2, 3,  3},
    '{2, 40, 4,   32, 1, 3,  6},
    '{2, 40, 4,    0, 3, 5,  2},
    '{2, 40, 8,   16, 0, 4, 10},
    '{0,  5, 8,    0, 0, 4,  5},
    '{1, 20, 2,  -16, 1, 2,  1},
    '{3, 20, 2, -200, 1, 1,  3},
    '{0, 63, 5,    0, 2, 4,  1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int mult, input int scale, input int frc,
                    input bit vld, input bit fe);
    req_mult = 7'(mult); req_scale = 8'(scale); req_force = 12'(frc);
    req_valid = vld; req_force_en = fe; req_wr = 1'b1;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ref_idx;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 mode", mode_state, 0);
    chk("R1 scale", out_scale, 0);
    chk("R1 flags", {flag_min, flag_max}, 0);
    chk("R1 index", out_index, 2);
    chk("R12 ready low when off", edge_ready, 0);

    // R2 off -> open first; R3 zero multiplier refuses closed
    mode_sel = 2'd2;
    cyc(1);
    chk("R2 via open", mode_state, 1);
    chk("R12 ready when on", edge_ready, 1);
    cyc(5);
    chk("R3 refused no request", mode_state, 1);
    wr(0, 9, 0, 1'b1, 1'b0);
    cyc(3);
    chk("R3 refused zero mult", mode_state, 1);
    wr(4, 9, 0, 1'b0, 1'b0);
    cyc(3);
    chk("R4 invalid write ignored", mode_state, 1);

    // stimulus vectors
    for (int i = 0; i < NV; i++) begin
      mode_sel = 2'd1;
      cyc(2);
      lim_min = 6'(VEC[i][0]); lim_max = 6'(VEC[i][1]);
      edge_valid = 1'b1; edge_cnt = 4'(VEC[i][4]);
      wr(VEC[i][2], i + 1, VEC[i][3], 1'b1, 1'b1);
      chk("R4 parked scale", out_scale, i);
      mode_sel = 2'd2;
      cyc(VEC[i][5] * 32 + 16);
      chk("R2 closed", mode_state, 2);
      chk("R4 scale on entry", out_scale, i + 1);
      chk("R6 R7 R10 index", out_index, VEC[i][6]);
    end

    // R10/R11 flags (open loop, no updates)
    mode_sel = 2'd1;
    cyc(2);
    chk("R10 min flag", flag_min, 1);
    chk("R10 max flag", flag_max, 1);
    clr_min = 1'b1; cyc(1); clr_min = 1'b0;
    chk("R11 min cleared", flag_min, 0);
    chk("R11 max kept", flag_max, 1);
    clr_max = 1'b1; cyc(1); clr_max = 1'b0;
    chk("R11 max cleared", flag_max, 0);

    // R9 live limits
    lim_min = 6'd10; #1;
    chk("R9 raised min", out_index, 10);
    lim_min = 6'd0; lim_max = 6'd0; #1;
    chk("R9 lowered max", out_index, 0);
    lim_max = 6'd63; #1;
    chk("R9 restored", out_index, 1);

    // R8 open loop holds despite large error
    edge_cnt = 4'd0;
    cyc(200);
    chk("R8 open hold", out_index, 1);

    // R4 closed-loop writes
    edge_cnt = 4'd2;
    mode_sel = 2'd2;
    cyc(2);
    wr(5, 8'h55, 0, 1'b1, 1'b0);
    chk("R4 closed immediate", out_scale, 8'h55);
    wr(5, 8'h11, 0, 1'b0, 1'b0);
    chk("R4 closed invalid", out_scale, 8'h55);
    wr(0, 8'h22, 0, 1'b1, 1'b0);
    chk("R4 closed zero mult", out_scale, 8'h55);

    // R5 zero divisor stops updates
    div_cfg = 8'd0;
    cyc(3);
    ref_idx = int'(out_index);
    cyc(200);
    chk("R5 zero divisor", out_index, ref_idx);

    // R5/R6 window of 64 cycles with preload
    mode_sel = 2'd1;
    cyc(2);
    wr(5, 3, 0, 1'b1, 1'b1);
    div_cfg = 8'd2;
    mode_sel = 2'd2;
    cyc(160);
    chk("R5 R6 two windows", out_index, 1);
    cyc(64);
    chk("R5 R6 three windows", out_index, 2);

    // R2 leave to disabled directly
    mode_sel = 2'd0;
    cyc(1);
    chk("R2 off", mode_state, 0);
    chk("R12 ready off", edge_ready, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule